// File: doc/BRIEF.md
# Charge Throttle with Termination Latch

The block drives the enable of a series charge switch from a set of per-cell flags. Each flag says that the bypass regulator of one cell is fully on. While no flag is active, the switch conducts and the charger delivers current. When any flag becomes active, the switch opens. Current stops, the highest cell relaxes, its flag drops and the switch closes again. This on/off cycling holds the highest cell at its set point.

Programmable minimum on and off dwell times, counted in ticks of an external time base, cap the switching rate. The defaults give about 200 Hz with a 100 kHz tick. The duty cycle still follows the flags, and the period stretches when the dwell limits apply.

When every flag is active at once for a set number of consecutive ticks, the pack counts as full. A sticky termination latch then opens the switch permanently until reset. A two-colour indicator shows red while the switch conducts and green while it is open.

Top module: `charge_throttle`

## Requirements
- R1: Every flag passes through two synchronizing flops. A flag change can affect `chg_en` no sooner than three clock edges after it is applied.
- R2: `chg_en` goes low only when at least one synchronized flag is active or the termination latch is set. It goes high only when no synchronized flag is active and the latch is clear.
- R3: After `chg_en` rises, it stays high for at least `MIN_ON_TICKS` tick pulses, even if a flag is active.
- R4: After `chg_en` falls, it stays low for at least `MIN_OFF_TICKS` tick pulses, even if all flags are clear.
- R5: When all synchronized flags are active on `ALL_HOLD_TICKS` consecutive tick pulses, `terminated` is set and `chg_en` falls on the next edge. If any flag drops before that count is reached, the count restarts and nothing is latched.
- R6: Once `terminated` is 1, it and `chg_en`=0 hold regardless of the flags until `rst`.
- R7: `led_red` equals `chg_en` and `led_green` equals its inverse, so exactly one of them is 1.
- R8: While `rst` is high and after it falls, `chg_en`=1, `led_red`=1, `led_green`=0 and `terminated`=0.
- R9: Clock cycles without a tick pulse do not advance the dwell or hold counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base pulse |
| shunt_full | input | N_CELLS | Per-cell bypass-fully-on flags, asynchronous |
| chg_en | output | 1 | Charge switch enable, 1 = conducting |
| led_red | output | 1 | Indicator red, switch conducting |
| led_green | output | 1 | Indicator green, switch open |
| terminated | output | 1 | Sticky end-of-charge latch |

## Verification
Faults in this block show up at the ports within a few cycles. A dwell counter that is wrong, or that counts cycles instead of ticks, moves an edge of `chg_en` away from the tick on which the model expects it. The bench catches this on the first throttle cycle. A hold counter that fails to restart, or that latches too early, raises `terminated` during a broken all-active run, while the model keeps it low. A lost or missing synchronizer stage shifts every switch edge by a cycle. Because the bench compares against its model on every clock, the first wrong cycle is reported.

// File: rtl/charge_throttle_pkg.sv
package charge_throttle_pkg;
  typedef enum logic {SW_OPEN = 1'b0, SW_CLOSED = 1'b1} sw_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cell_flag_sync.sv
module cell_flag_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk) begin
      if (rst) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= d[i];
        st2 <= st1;
      end
    end
    assign q[i] = st2;
  end
endmodule

// File: rtl/shunt_vote.sv
module shunt_vote #(
  parameter int W = 4
) (
  input  logic [W-1:0] flags,
  output logic         any_o,
  output logic         all_o
);
  always_comb begin
    any_o = |flags;
    all_o = &flags;
  end
endmodule

// File: rtl/full_term_latch.sv
module full_term_latch #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic all_i,
  output logic term_o
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      term_o  <= 1'b0;
    end else begin
      if (!all_i) begin
        run_cnt <= '0;
      end else if (tick) begin
        if (run_cnt == LAST) term_o <= 1'b1;
        else                 run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R5
  term_needs_all_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(term_o) |-> $past(all_i) && $past(tick));
  // R6
  term_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(term_o) |-> term_o);
endmodule

// File: rtl/switch_dwell_ctrl.sv
module switch_dwell_ctrl
  import charge_throttle_pkg::*;
#(
  parameter int MIN_ON  = 250,
  parameter int MIN_OFF = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic any_i,
  input  logic term_i,
  output logic en_o
);
  localparam int MAXD = max2(MIN_ON, MIN_OFF);
  localparam int DW   = $clog2(MAXD + 1);
  localparam logic [DW-1:0] DMAX  = DW'(MAXD);
  localparam logic [DW-1:0] D_ON  = DW'(MIN_ON);
  localparam logic [DW-1:0] D_OFF = DW'(MIN_OFF);

  sw_state_t       st;
  logic [DW-1:0]   dwell;
  logic            flip;

  always_comb begin
    if (st == SW_CLOSED) flip = term_i || (any_i && dwell >= D_ON);
    else                 flip = !term_i && !any_i && dwell >= D_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SW_CLOSED;
      dwell <= '0;
    end else if (flip) begin
      st    <= (st == SW_CLOSED) ? SW_OPEN : SW_CLOSED;
      dwell <= '0;
    end else if (tick && dwell != DMAX) begin
      dwell <= dwell + 1'b1;
    end
  end

  assign en_o = (st == SW_CLOSED);

  // R2
  open_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(en_o) |-> ($past(any_i) || $past(term_i)));
  // R2
  close_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en_o) |-> ($past(!any_i) && $past(!term_i)));
endmodule

// File: rtl/charge_throttle.sv
module charge_throttle #(
  parameter int N_CELLS        = 4,
  parameter int MIN_ON_TICKS   = 250,
  parameter int MIN_OFF_TICKS  = 250,
  parameter int ALL_HOLD_TICKS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [N_CELLS-1:0] shunt_full,
  output logic               chg_en,
  output logic               led_red,
  output logic               led_green,
  output logic               terminated
);
  logic [N_CELLS-1:0] flags_s;
  logic any_s, all_s, term_q, en_q;

  cell_flag_sync #(.W(N_CELLS)) u_sync (
    .clk(clk), .rst(rst), .d(shunt_full), .q(flags_s));

  shunt_vote #(.W(N_CELLS)) u_vote (
    .flags(flags_s), .any_o(any_s), .all_o(all_s));

  full_term_latch #(.HOLD(ALL_HOLD_TICKS)) u_term (
    .clk(clk), .rst(rst), .tick(tick), .all_i(all_s), .term_o(term_q));

  switch_dwell_ctrl #(.MIN_ON(MIN_ON_TICKS), .MIN_OFF(MIN_OFF_TICKS)) u_sw (
    .clk(clk), .rst(rst), .tick(tick), .any_i(any_s), .term_i(term_q),
    .en_o(en_q));

  assign chg_en     = en_q;
  assign led_red    = en_q;
  assign led_green  = ~en_q;
  assign terminated = term_q;

  // R7
  led_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({led_red, led_green}) == 1);
  // R6
  term_forces_open_chk: assert property (@(posedge clk) disable iff (rst)
    (terminated && $past(terminated)) |-> !chg_en);
endmodule

// File: tb/charge_throttle_test.sv
module charge_throttle_test;
  localparam int N = 4;
  localparam int MON = 3;
  localparam int MOFF = 4;
  localparam int HOLD = 8;
  localparam int MAXD = (MON > MOFF) ? MON : MOFF;

  logic clk = 0, rst = 1, tick = 0;
  logic [N-1:0] flags = '0;
  logic chg_en, led_red, led_green, terminated;

  int checks = 0, failures = 0, cycles = 0;
  bit tick_run = 1;
  int tick_div = 0;
  string tag = "R8";

  charge_throttle #(.N_CELLS(N), .MIN_ON_TICKS(MON), .MIN_OFF_TICKS(MOFF),
                    .ALL_HOLD_TICKS(HOLD)) uut (
    .clk(clk), .rst(rst), .tick(tick), .shunt_full(flags),
    .chg_en(chg_en), .led_red(led_red), .led_green(led_green),
    .terminated(terminated));

  always #5 clk = ~clk;

  // behavioural reference
  logic [N-1:0] dly[$];
  bit m_en = 1, m_term = 0;
  int m_dwell = 0, m_run = 0;

  always @(posedge clk) begin
    logic [N-1:0] s;
    bit any, all, nt;
    if (rst) begin
      dly = {'0, '0};
      m_en = 1; m_term = 0; m_dwell = 0; m_run = 0;
    end else begin
      s = dly.pop_front();
      dly.push_back(flags);
      any = (s != 0);
      all = (s == {N{1'b1}});
      nt = m_term;
      if (!all) m_run = 0;
      else if (tick) begin
        if (m_run == HOLD - 1) nt = 1;
        else m_run++;
      end
      if (m_en && (m_term || (any && m_dwell >= MON))) begin
        m_en = 0; m_dwell = 0;
      end else if (!m_en && !m_term && !any && m_dwell >= MOFF) begin
        m_en = 1; m_dwell = 0;
      end else if (tick && m_dwell < MAXD) m_dwell++;
      m_term = nt;
    end
  end

  task automatic chk(input string t, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", t, nm, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk(tag, "chg_en", chg_en, m_en);
    chk("R7", "led_red", led_red, m_en);
    chk("R7", "led_green", led_green, !m_en);
    chk(tag, "terminated", terminated, m_term);
    if (tick_run && tick_div == 4) begin tick = 1; tick_div = 0; end
    else begin tick = 0; if (tick_run) tick_div++; end
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tag = "R8";
    wait_cyc(4);
    chk("R8", "chg_en in reset", chg_en, 1'b1);
    chk("R8", "terminated in reset", terminated, 1'b0);
    rst = 0;
    wait_cyc(1);
    chk("R8", "chg_en after reset", chg_en, 1'b1);

    tag = "R2";
    wait_cyc(40);
    chk("R2", "idle stays closed", chg_en, 1'b1);

    // R1: latency of three edges after a flag rises
    tag = "R1";
    flags = 4'b0001;
    wait_cyc(2);
    chk("R1", "no early open", chg_en, 1'b1);
    wait_cyc(1);
    chk("R1", "open after sync", chg_en, 1'b0);

    // R3 R4: throttling with varied flag widths
    tag = "R3";
    for (int i = 0; i < 6; i++) begin
      flags = (i % 2) ? 4'b0100 : 4'b0011;
      wait_cyc(7 + i * 9);
      tag = "R4";
      flags = '0;
      wait_cyc(5 + i * 11);
      tag = "R3";
    end
    // short flag pulses right after closing
    for (int i = 0; i < 8; i++) begin
      flags = 4'b1000; wait_cyc(3);
      flags = '0;      wait_cyc(2 + i);
    end

    // R9: timers frozen without ticks
    tag = "R9";
    tick_run = 0;
    flags = 4'b0010; wait_cyc(30);
    flags = '0;      wait_cyc(30);
    chk("R9", "frozen dwell keeps state", chg_en, m_en);
    tick_run = 1;
    wait_cyc(60);

    // R5: all active but broken before the hold count
    tag = "R5";
    flags = '1; wait_cyc(5 * (HOLD - 3));
    flags = 4'b1110; wait_cyc(3);
    flags = '1; wait_cyc(5 * (HOLD - 3));
    flags = '0; wait_cyc(60);
    chk("R5", "no latch on broken run", terminated, 1'b0);

    // R5: full hold latches
    flags = '1; wait_cyc(5 * HOLD + 12);
    chk("R5", "latched", terminated, 1'b1);
    chk("R5", "switch open", chg_en, 1'b0);

    // R6: sticky regardless of flags
    tag = "R6";
    flags = '0; wait_cyc(80);
    chk("R6", "still terminated", terminated, 1'b1);
    chk("R6", "still open", chg_en, 1'b0);
    flags = 4'b0101; wait_cyc(20);

    // R8: reset clears
    tag = "R8";
    rst = 1; wait_cyc(3);
    rst = 0; flags = '0; wait_cyc(2);
    chk("R8", "latch cleared", terminated, 1'b0);
    chk("R8", "switch closed", chg_en, 1'b1);
    wait_cyc(20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule